// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block powers up and releases a PCIe root-port controller, its PHY and the attached endpoint in a fixed, timed order. After a `start` pulse it keeps the PHY powered down while it holds the endpoint in reset for a set time. It then enables endpoint power, takes the PHY out of power-down and turns on the PHY reference clock. Next it enables four clocks one after another. Each clock must be acknowledged before the next one starts. If any acknowledge is late, the clocks already enabled are switched off again in reverse order.

Once every clock is running and a settle time has passed, the block asks an external agent to set up the controller through a request/done handshake. When setup is done it enables link training. It then samples the link-up indication at fixed intervals, up to a bounded number of times. It finishes in either a ready state or a failed state, and the failed state carries a cause code. Every delay is a parameter counted in clock cycles. Clock index 0 is the 100 MHz storage reference, 1 is the 125 MHz PCIe reference, 2 is the display-link gate and 3 is the bus interface clock.

Top module: `pcie_rp_bringup_seq`

## Requirements
- R1: While and after synchronous reset the outputs are: `ep_reset_n`=0, `pwr_en`=0, `ep_disable`=1, `phy_test_pd`=1, `refclk_en`=0, `clk_en`=0, `ltssm_en`=0, `setup_req`=0, `busy`=0, `ready`=0, `fail`=0 and `fail_code`=2'b00.
- R2: A `start` pulse is accepted when the block is idle, ready or failed, and is ignored while `busy`=1. Once a pulse is accepted, `ep_reset_n` stays low for exactly RST_PULSE_CYC cycles. While it is low, `phy_test_pd`=1, `refclk_en`=0, `clk_en`=0 and `ltssm_en`=0.
- R3: In the cycle `ep_reset_n` rises, `pwr_en` also rises and `ep_disable` falls. One cycle later `phy_test_pd` falls, and one cycle after that `refclk_en` rises.
- R4: `clk_en[0]` rises one cycle after `refclk_en`. `clk_en[i+1]` rises in the cycle after the edge that samples `clk_ack[i]`=1. Clocks are enabled only in ascending index order, one per step.
- R5: If `clk_ack[i]` is still 0 at the CLK_ACK_TMO-th edge after `clk_en[i]` rose, `clk_en[i]` drops at that edge. Each lower enable then drops one per cycle, highest index first. `fail` rises with `fail_code`=2'b01 two cycles after the last drop, and every `clk_en` bit is then 0.
- R6: After the edge that samples the last acknowledge, `setup_req` rises SETTLE_CYC+1 cycles later.
- R7: `setup_req` stays high until `setup_done` is sampled high. In the next cycle `setup_req` is low and `ltssm_en` is high. Training is never enabled unless all clocks are enabled.
- R8: `link_up` is sampled only every POLL_GAP_CYC cycles after `ltssm_en` rises, and is ignored between samples. If it is first seen at sample k, `ready` rises k*POLL_GAP_CYC cycles after `ltssm_en`, with `fail_code`=2'b00.
- R9: If POLL_MAX samples all see `link_up`=0, then `fail` rises with `fail_code`=2'b10 exactly POLL_MAX*POLL_GAP_CYC cycles after `ltssm_en` rose, and `ltssm_en` drops.
- R10: `busy` is high from the cycle after an accepted start until `ready` or `fail` rises. `busy`, `ready` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up sequence |
| setup_done | input | 1 | External controller setup finished |
| link_up | input | 1 | Link-up indication from the controller |
| clk_ack | input | NUM_CLK | Per-clock enable acknowledge |
| ep_reset_n | output | 1 | Endpoint reset, active low |
| pwr_en | output | 1 | Endpoint power enable |
| ep_disable | output | 1 | Endpoint disable, high until power is applied |
| phy_test_pd | output | 1 | PHY test power-down |
| refclk_en | output | 1 | PHY reference clock enable |
| clk_en | output | NUM_CLK | Clock gate enables, bit 0 first |
| setup_req | output | 1 | Request for external controller setup |
| ltssm_en | output | 1 | Link-training enable |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Link is up |
| fail | output | 1 | Sequence failed |
| fail_code | output | 2 | 00 none, 01 clock acknowledge timeout, 10 link never came up |

## Verification
The assertions assume that `clk_ack[i]` is driven only as a response to `clk_en[i]` and never runs ahead of it. They also assume that `setup_done` is raised only while `setup_req` is high. The bench's acknowledge model derives each acknowledge from the matching enable after a chosen latency and clears it when the enable drops. The bench pulses `setup_done` for one cycle only in response to a seen request. It drives `link_up` freely, including stray pulses between samples, because the block must tolerate any value there.

// File: rtl/rpbu_pkg.sv
package rpbu_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_PWR,
        ST_UNPD,
        ST_REF,
        ST_CLK,
        ST_SETTLE,
        ST_SETUP,
        ST_TRAIN,
        ST_UP,
        ST_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_CLOCK = 2'b01,
        FC_LINK  = 2'b10
    } fail_code_e;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_WAIT,
        CH_UNWIND,
        CH_DONE,
        CH_FAIL
    } chain_phase_e;

    typedef struct packed {
        logic ep_reset_n;
        logic pwr_en;
        logic ep_disable;
        logic phy_test_pd;
        logic refclk_en;
        logic ltssm_en;
        logic setup_req;
        logic busy;
        logic ready;
        logic fail;
    } ctl_out_t;

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Control lines are a pure function of the sequence step.
    function automatic ctl_out_t decode_state(input seq_state_e s);
        ctl_out_t o;
        o             = '0;
        o.ep_reset_n  = !(s inside {ST_IDLE, ST_HOLD});
        o.pwr_en      = o.ep_reset_n;
        o.ep_disable  = !o.ep_reset_n;
        o.phy_test_pd = (s inside {ST_IDLE, ST_HOLD, ST_PWR});
        o.refclk_en   = !(s inside {ST_IDLE, ST_HOLD, ST_PWR, ST_UNPD});
        o.ltssm_en    = (s inside {ST_TRAIN, ST_UP});
        o.setup_req   = (s == ST_SETUP);
        o.busy        = !(s inside {ST_IDLE, ST_UP, ST_FAIL});
        o.ready       = (s == ST_UP);
        o.fail        = (s == ST_FAIL);
        return o;
    endfunction

endpackage

// File: rtl/rpbu_delay.sv
module rpbu_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/rpbu_clk_chain.sv
module rpbu_clk_chain
    import rpbu_pkg::*;
#(
    parameter int N   = 4,
    parameter int TMO = 1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         kick,
    input  logic [N-1:0] ack,
    output logic [N-1:0] en,
    output logic         done,
    output logic         failed
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int TW = $clog2(TMO + 1);
    localparam logic [N-1:0]  ONE  = N'(1);
    localparam logic [IW-1:0] LAST = IW'(N - 1);
    localparam logic [TW-1:0] TLIM = TW'(TMO - 1);

    chain_phase_e  ph;
    logic [IW-1:0] idx;
    logic [IW-1:0] idx_up;
    logic [IW-1:0] idx_dn;
    logic [TW-1:0] tmo;
    logic          cur_ack;

    assign idx_up  = idx + IW'(1);
    assign idx_dn  = idx - IW'(1);
    assign cur_ack = ack[idx];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ph  <= CH_IDLE;
            en  <= '0;
            idx <= '0;
            tmo <= '0;
        end else begin
            case (ph)
                CH_IDLE: begin
                    if (kick) begin
                        en  <= ONE;
                        idx <= '0;
                        tmo <= '0;
                        ph  <= CH_WAIT;
                    end
                end
                CH_WAIT: begin
                    if (cur_ack) begin
                        if (idx == LAST) begin
                            ph <= CH_DONE;
                        end else begin
                            en  <= en | (ONE << idx_up);
                            idx <= idx_up;
                            tmo <= '0;
                        end
                    end else if (tmo == TLIM) begin
                        // The stalled clock is switched off first.
                        en <= en & ~(ONE << idx);
                        ph <= CH_UNWIND;
                    end else begin
                        tmo <= tmo + TW'(1);
                    end
                end
                CH_UNWIND: begin
                    if (idx == '0) begin
                        ph <= CH_FAIL;
                    end else begin
                        en  <= en & ~(ONE << idx_dn);
                        idx <= idx_dn;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done   = (ph == CH_DONE);
    assign failed = (ph == CH_FAIL);
endmodule

// File: rtl/rpbu_link_poll.sv
module rpbu_link_poll #(
    parameter int GAP = 10000,
    parameter int MAX = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic link_up,
    output logic hit,
    output logic gave_up
);
    localparam int GW = $clog2(GAP + 1);
    localparam int CW = $clog2(MAX + 1);
    localparam logic [GW-1:0] GRELOAD = GW'(GAP - 1);
    localparam logic [CW-1:0] CLAST   = CW'(MAX - 1);

    logic          active;
    logic [GW-1:0] gap_cnt;
    logic [CW-1:0] tries;
    logic          sample;

    assign sample  = active && (gap_cnt == '0);
    assign hit     = sample && link_up;
    assign gave_up = sample && !link_up && (tries == CLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            gap_cnt <= '0;
            tries   <= '0;
        end else if (arm) begin
            active  <= 1'b1;
            gap_cnt <= GRELOAD;
            tries   <= '0;
        end else if (active) begin
            if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - GW'(1);
            end else if (link_up || tries == CLAST) begin
                active <= 1'b0;
            end else begin
                tries   <= tries + CW'(1);
                gap_cnt <= GRELOAD;
            end
        end
    end
endmodule

// File: rtl/pcie_rp_bringup_seq.sv
module pcie_rp_bringup_seq
    import rpbu_pkg::*;
#(
    parameter int NUM_CLK       = 4,
    parameter int RST_PULSE_CYC = 10000000,
    parameter int CLK_ACK_TMO   = 1000,
    parameter int SETTLE_CYC    = 20000,
    parameter int POLL_GAP_CYC  = 10000,
    parameter int POLL_MAX      = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               setup_done,
    input  logic               link_up,
    input  logic [NUM_CLK-1:0] clk_ack,
    output logic               ep_reset_n,
    output logic               pwr_en,
    output logic               ep_disable,
    output logic               phy_test_pd,
    output logic               refclk_en,
    output logic [NUM_CLK-1:0] clk_en,
    output logic               setup_req,
    output logic               ltssm_en,
    output logic               busy,
    output logic               ready,
    output logic               fail,
    output logic [1:0]         fail_code
);
    localparam int TMR_W = $clog2(wmax(RST_PULSE_CYC, SETTLE_CYC) + 1);
    localparam logic [TMR_W-1:0] HOLD_LOAD   = TMR_W'(RST_PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYC - 1);

    seq_state_e       st;
    seq_state_e       st_nx;
    fail_code_e       fc;
    ctl_out_t         ctl;
    logic             go;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             ch_kick;
    logic             ch_done;
    logic             ch_failed;
    logic             poll_arm;
    logic             poll_hit;
    logic             poll_quit;

    assign go       = start && (st inside {ST_IDLE, ST_UP, ST_FAIL});
    assign ch_kick  = (st == ST_REF);
    assign poll_arm = (st == ST_SETUP) && setup_done;
    assign tmr_load = go || ((st == ST_CLK) && ch_done);
    assign tmr_val  = go ? HOLD_LOAD : SETTLE_LOAD;

    // One counter serves both the reset hold and the clock settle time.
    rpbu_delay #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rpbu_clk_chain #(.N(NUM_CLK), .TMO(CLK_ACK_TMO)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .clear  (go),
        .kick   (ch_kick),
        .ack    (clk_ack),
        .en     (clk_en),
        .done   (ch_done),
        .failed (ch_failed)
    );

    rpbu_link_poll #(.GAP(POLL_GAP_CYC), .MAX(POLL_MAX)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .arm     (poll_arm),
        .link_up (link_up),
        .hit     (poll_hit),
        .gave_up (poll_quit)
    );

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE, ST_UP, ST_FAIL: if (start) st_nx = ST_HOLD;
            ST_HOLD:   if (tmr_zero) st_nx = ST_PWR;
            ST_PWR:    st_nx = ST_UNPD;
            ST_UNPD:   st_nx = ST_REF;
            ST_REF:    st_nx = ST_CLK;
            ST_CLK: begin
                if (ch_done)        st_nx = ST_SETTLE;
                else if (ch_failed) st_nx = ST_FAIL;
            end
            ST_SETTLE: if (tmr_zero) st_nx = ST_SETUP;
            ST_SETUP:  if (setup_done) st_nx = ST_TRAIN;
            ST_TRAIN: begin
                if (poll_hit)       st_nx = ST_UP;
                else if (poll_quit) st_nx = ST_FAIL;
            end
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            fc <= FC_NONE;
        end else begin
            st <= st_nx;
            if (go) begin
                fc <= FC_NONE;
            end else if ((st == ST_CLK) && !ch_done && ch_failed) begin
                fc <= FC_CLOCK;
            end else if ((st == ST_TRAIN) && !poll_hit && poll_quit) begin
                fc <= FC_LINK;
            end
        end
    end

    assign ctl         = decode_state(st);
    assign ep_reset_n  = ctl.ep_reset_n;
    assign pwr_en      = ctl.pwr_en;
    assign ep_disable  = ctl.ep_disable;
    assign phy_test_pd = ctl.phy_test_pd;
    assign refclk_en   = ctl.refclk_en;
    assign setup_req   = ctl.setup_req;
    assign ltssm_en    = ctl.ltssm_en;
    assign busy        = ctl.busy;
    assign ready       = ctl.ready;
    assign fail        = ctl.fail;
    assign fail_code   = fc;
endmodule

// File: rtl/rpbu_chk.sv
module rpbu_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         ep_reset_n,
    input logic         pwr_en,
    input logic         phy_test_pd,
    input logic         refclk_en,
    input logic [N-1:0] clk_en,
    input logic         setup_req,
    input logic         setup_done,
    input logic         ltssm_en,
    input logic         busy,
    input logic         ready,
    input logic         fail,
    input logic [1:0]   fail_code
);
    localparam logic [N-1:0] ONE = N'(1);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    p_hold_safe_r2: assert property (@(posedge clk) disable iff (rst)
        !ep_reset_n |-> (phy_test_pd && !refclk_en && clk_en == '0 && !ltssm_en));

    p_pwr_before_unpd_r3: assert property (@(posedge clk) disable iff (rst)
        !phy_test_pd |-> (pwr_en && ep_reset_n));

    p_ref_after_unpd_r3: assert property (@(posedge clk) disable iff (rst)
        refclk_en |-> !phy_test_pd);

    p_clk_needs_ref_r4: assert property (@(posedge clk) disable iff (rst)
        (clk_en != '0) |-> refclk_en);

    p_clk_rise_order_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && ((clk_en & ~$past(clk_en)) != '0)) |->
        ($onehot(clk_en & ~$past(clk_en)) &&
         ($past(clk_en) == ((clk_en & ~$past(clk_en)) - ONE))));

    p_unwind_reverse_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && ep_reset_n && (($past(clk_en) & ~clk_en) != '0)) |->
        ($onehot($past(clk_en) & ~clk_en) &&
         (clk_en < ($past(clk_en) & ~clk_en)) &&
         ((clk_en & ~$past(clk_en)) == '0)));

    p_setup_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (setup_req && !setup_done) |=> setup_req);

    p_train_after_clocks_r7: assert property (@(posedge clk) disable iff (rst)
        ltssm_en |-> (clk_en == '1));

    p_fail_code_r9: assert property (@(posedge clk) disable iff (rst)
        fail |-> (fail_code != 2'b00));

    p_code_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !fail |-> (fail_code == 2'b00));

    p_status_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({busy, ready, fail}) <= 1);
endmodule

bind pcie_rp_bringup_seq rpbu_chk #(.N(NUM_CLK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ep_reset_n  (ep_reset_n),
    .pwr_en      (pwr_en),
    .phy_test_pd (phy_test_pd),
    .refclk_en   (refclk_en),
    .clk_en      (clk_en),
    .setup_req   (setup_req),
    .setup_done  (setup_done),
    .ltssm_en    (ltssm_en),
    .busy        (busy),
    .ready       (ready),
    .fail        (fail),
    .fail_code   (fail_code)
);

// File: tb/sim_pcie_rp_bringup_seq.sv
`timescale 1ns/1ps
module sim_pcie_rp_bringup_seq;
    localparam int NC     = 4;
    localparam int RSTC   = 20;
    localparam int TMO    = 6;
    localparam int SETTLE = 12;
    localparam int GAP    = 5;
    localparam int PMAX   = 10;
    localparam int LIMIT  = 400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          setup_done = 1'b0;
    logic          link_up = 1'b0;
    logic [NC-1:0] clk_ack = '0;
    logic          ep_reset_n, pwr_en, ep_disable, phy_test_pd, refclk_en;
    logic [NC-1:0] clk_en;
    logic          setup_req, ltssm_en, busy, ready, fail;
    logic [1:0]    fail_code;

    int total = 0;
    int bad   = 0;
    int lat [NC];
    int hcnt[NC];

    pcie_rp_bringup_seq #(
        .NUM_CLK(NC), .RST_PULSE_CYC(RSTC), .CLK_ACK_TMO(TMO),
        .SETTLE_CYC(SETTLE), .POLL_GAP_CYC(GAP), .POLL_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .setup_done(setup_done),
        .link_up(link_up), .clk_ack(clk_ack), .ep_reset_n(ep_reset_n),
        .pwr_en(pwr_en), .ep_disable(ep_disable), .phy_test_pd(phy_test_pd),
        .refclk_en(refclk_en), .clk_en(clk_en), .setup_req(setup_req),
        .ltssm_en(ltssm_en), .busy(busy), .ready(ready), .fail(fail),
        .fail_code(fail_code)
    );

    initial forever #5 clk = ~clk;

    // Acknowledge model: ack[i] follows clk_en[i] after lat[i] cycles.
    initial begin
        for (int i = 0; i < NC; i++) begin
            hcnt[i] = 0;
            lat[i]  = 1;
        end
        forever begin
            @(negedge clk);
            for (int i = 0; i < NC; i++) begin
                if (clk_en[i]) hcnt[i] = hcnt[i] + 1;
                else           hcnt[i] = 0;
                clk_ack[i] = clk_en[i] && (hcnt[i] >= lat[i]);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_seq(input int l0, input int l1, input int l2, input int l3,
                           input int fidx, input int lk, input int sd,
                           input bit mid, input bit stray);
        int rn, pn, dn, pdn, rfn, rqn, rqf, ltn, rdn, fln, holdbad, busybad, sumlat, lastdrop;
        int enr[NC];
        int enf[NC];
        logic p_rstn, p_pwr, p_dis, p_pd, p_ref, p_req, p_lt, p_rdy, p_fail;
        logic [NC-1:0] p_en;
        rn = -1; pn = -1; dn = -1; pdn = -1; rfn = -1; rqn = -1; rqf = -1;
        ltn = -1; rdn = -1; fln = -1; holdbad = 0; busybad = 0;
        for (int i = 0; i < NC; i++) begin
            enr[i] = -1;
            enf[i] = -1;
        end
        lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
        @(negedge clk);
        start = 1'b1;
        p_rstn = ep_reset_n; p_pwr = pwr_en; p_dis = ep_disable; p_pd = phy_test_pd;
        p_ref = refclk_en; p_req = setup_req; p_lt = ltssm_en; p_rdy = ready;
        p_fail = fail; p_en = clk_en;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < LIMIT; n++) begin
            if (n > 0) @(negedge clk);
            if (!ep_reset_n && (!phy_test_pd || refclk_en || clk_en != '0 || ltssm_en))
                holdbad++;
            if (busy == (ready || fail)) busybad++;
            if (ep_reset_n && !p_rstn && rn < 0) rn = n;
            if (pwr_en && !p_pwr && pn < 0) pn = n;
            if (!ep_disable && p_dis && dn < 0) dn = n;
            if (!phy_test_pd && p_pd && pdn < 0) pdn = n;
            if (refclk_en && !p_ref && rfn < 0) rfn = n;
            if (setup_req && !p_req && rqn < 0) rqn = n;
            if (!setup_req && p_req && rqn >= 0 && rqf < 0) rqf = n;
            if (ltssm_en && !p_lt && ltn < 0) ltn = n;
            if (ready && !p_rdy && rdn < 0) rdn = n;
            if (fail && !p_fail && fln < 0) fln = n;
            for (int i = 0; i < NC; i++) begin
                if (clk_en[i] && !p_en[i] && enr[i] < 0) enr[i] = n;
                if (!clk_en[i] && p_en[i] && enr[i] >= 0 && enf[i] < 0) enf[i] = n;
            end
            p_rstn = ep_reset_n; p_pwr = pwr_en; p_dis = ep_disable; p_pd = phy_test_pd;
            p_ref = refclk_en; p_req = setup_req; p_lt = ltssm_en; p_rdy = ready;
            p_fail = fail; p_en = clk_en;
            setup_done = (rqn >= 0 && rqf < 0 && n == rqn + sd);
            if (ltn >= 0 && lk > 0 && n >= ltn + (lk - 1) * GAP) link_up = 1'b1;
            else if (stray && ltn >= 0 && n == ltn + 2)           link_up = 1'b1;
            else                                                   link_up = 1'b0;
            start = mid && (n == 5 || (ltn >= 0 && n == ltn + 1));
            if (rdn >= 0 && n >= rdn + 2) break;
            if (fln >= 0 && n >= fln + 2) break;
        end
        start = 1'b0; setup_done = 1'b0; link_up = 1'b0;

        chk("R2 reset hold length", rn, RSTC);
        chk("R2 hold-phase safety violations", holdbad, 0);
        chk("R3 power enable timing", pn, RSTC);
        chk("R3 endpoint disable release", dn, RSTC);
        chk("R3 test power-down release", pdn, RSTC + 1);
        chk("R3 reference clock enable", rfn, RSTC + 2);
        chk("R10 busy versus status", busybad, 0);
        sumlat = RSTC + 3;
        for (int i = 0; i < NC; i++) begin
            if (fidx < 0 || i <= fidx) chk($sformatf("R4 clk_en[%0d] rise", i), enr[i], sumlat);
            sumlat = sumlat + lat[i];
        end
        if (fidx >= 0) begin
            chk("R5 stalled clock drop", enf[fidx], enr[fidx] + TMO);
            for (int j = 0; j < fidx; j++)
                chk($sformatf("R5 unwind clk_en[%0d]", j), enf[j], enr[fidx] + TMO + (fidx - j));
            lastdrop = enr[fidx] + TMO + fidx;
            chk("R5 fail timing", fln, lastdrop + 2);
            chk("R5 fail code", int'(fail_code), 1);
            chk("R5 enables cleared", int'(clk_en), 0);
            chk("R5 no training", ltn, -1);
        end else begin
            chk("R6 setup request timing", rqn, sumlat + 1 + SETTLE);
            chk("R7 training enable timing", ltn, rqn + sd + 1);
            chk("R7 setup request drop", rqf, ltn);
            if (lk > 0) begin
                chk($sformatf("R8 ready at poll %0d", lk), rdn, ltn + lk * GAP);
                chk("R8 code none", int'(fail_code), 0);
                chk("R10 ready only", int'({busy, ready, fail}), 3'b010);
            end else begin
                chk("R9 link fail timing", fln, ltn + PMAX * GAP);
                chk("R9 fail code", int'(fail_code), 2);
                chk("R9 training dropped", int'(ltssm_en), 0);
                chk("R10 fail only", int'({busy, ready, fail}), 3'b001);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ep_reset_n in reset", int'(ep_reset_n), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ep_reset_n", int'(ep_reset_n), 0);
        chk("R1 pwr_en", int'(pwr_en), 0);
        chk("R1 ep_disable", int'(ep_disable), 1);
        chk("R1 phy_test_pd", int'(phy_test_pd), 1);
        chk("R1 refclk_en", int'(refclk_en), 0);
        chk("R1 clk_en", int'(clk_en), 0);
        chk("R1 ltssm_en", int'(ltssm_en), 0);
        chk("R1 setup_req", int'(setup_req), 0);
        chk("R1 status", int'({busy, ready, fail}), 0);
        chk("R1 fail_code", int'(fail_code), 0);

        run_seq(1, 1, 1, 1, -1, 1, 0, 1'b0, 1'b0);
        run_seq(2, 3, 1, 4, -1, 3, 2, 1'b1, 1'b0);
        run_seq(TMO, TMO, TMO, TMO, -1, 10, 1, 1'b0, 1'b0);
        for (int f = 0; f < NC; f++) begin
            int l[NC];
            for (int i = 0; i < NC; i++) l[i] = (i == f) ? TMO + 1 : 2;
            run_seq(l[0], l[1], l[2], l[3], f, 1, 0, 1'b0, 1'b0);
        end
        run_seq(1, 2, 1, 3, -1, 0, 0, 1'b0, 1'b1);
        run_seq(3, 1, 2, 1, -1, 0, 3, 1'b1, 1'b0);
        for (int k = 1; k <= PMAX; k++) run_seq(1, 2, 1, 3, -1, k, k % 3, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule